// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This unit computes memory addresses for the load/store path of a signal-processing core. It keeps four independent register sets. Each set holds a pointer, a modifier, a base and a length. A command picks a set and gives the addressing form and the update rule. The unit returns the effective address, the access size and the new pointer value. Circular buffers may sit at any base and have any length, because the wrap is done by compare and add rather than by masking. The bit-reverse update lets FFT-style reordering walk a buffer with a single register.

Every accepted command spends one cycle in a result stage. Its outputs appear in the cycle after acceptance, and its pointer write-back lands at the end of that cycle. If a command arrives for a set whose pointer is still waiting in the stage, `cmd_ready` drops for one cycle and the command is held.

The control follows a two-state machine:
- **ST_IDLE**: the result stage is empty.
- **ST_BUSY**: the result stage holds a command.

Its transitions are:
- **T_ISSUE**: ST_IDLE to ST_BUSY when a command is accepted.
- **T_CHAIN**: ST_BUSY to ST_BUSY when the next command is accepted.
- **T_DRAIN**: ST_BUSY to ST_IDLE when nothing is accepted, either because no command is offered or because of a dependency stall.

Top module: `agu_addr_gen`

## Requirements
- R1: After reset, every pointer, modifier, base and length register is zero, `out_valid` is 0 and `cmd_ready` is 1.
- R2: Post-modify (`cmd_pre`=0) returns the current pointer as `out_addr`, and `out_ptr` and the stored pointer take the updated value.
- R3: Pre-modify (`cmd_pre`=1) returns the updated value as `out_addr`, and the stored pointer is unchanged (`out_ptr` equals the old pointer).
- R4: With `cmd_use_reg`=1 the modifier is the selected set's modifier register. With `cmd_use_reg`=0 it is `cmd_imm`. Both are signed two's complement.
- R5: Update code `cmd_upd`=1 (circular) with a nonzero length computes pointer+modifier. If the result is at or above base+length, length is subtracted. If it is below base, length is added. This happens in the same operation, for any base and length.
- R6: Code 0 (linear) and code 1 with length zero both give plain pointer+modifier modulo 2^32. Code 3 leaves the pointer as it is.
- R7: A circular update whose modifier magnitude exceeds a nonzero length sets `out_err`, leaves the pointer unchanged and uses the old pointer as the address.
- R8: Code 2 (bit-reverse) adds the modifier with the carry running from bit 31 down toward bit 0.
- R9: `out_size` repeats the accepted `cmd_size` (0 single, 1 dual, 2 quad word).
- R10: The outputs of a command accepted at one clock edge are valid for exactly the following cycle. Commands to different sets are accepted back to back.
- R11: A command that selects a set whose post-modify update (codes 0 to 2) is still in the result stage sees `cmd_ready`=0 for exactly one cycle and is accepted in the next cycle.
- R12: A register written through the write port (`wr_kind` 0 pointer, 1 modifier, 2 base, 3 length) is used by every command accepted from the next cycle on. A port write to a pointer beats a same-cycle write-back to that pointer.
- R13: The four register sets are independent: writes or updates to one set leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cmd_pre | input | 1 | 1 pre-modify, 0 post-modify |
| cmd_upd | input | 2 | Update rule: 0 linear, 1 circular, 2 bit-reverse, 3 none |
| cmd_idx | input | 2 | Register set select |
| cmd_use_reg | input | 1 | 1 modifier register, 0 immediate |
| cmd_imm | input | 32 | Immediate modifier |
| cmd_size | input | 2 | Access size code |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind written |
| wr_idx | input | 2 | Register set written |
| wr_data | input | 32 | Write value |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective address |
| out_size | output | 2 | Access size of the result |
| out_ptr | output | 32 | Pointer value after the command |
| out_err | output | 1 | Circular modifier out of range |

## Verification
The bench builds the unit with its defaults: 32-bit addresses and four register sets. These defaults expose the bit-31 carry entry of the bit-reverse add and circular buffers whose base plus length crosses the top of the address space. Random commands run over all four sets, with short lengths and small signed modifiers so that wraps in both directions and out-of-range errors occur often. Directed sequences cover the one-cycle stall, the collision between a port write and a write-back, and literal bit-reverse steps.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
    typedef enum logic [1:0] {
        UPD_LIN  = 2'd0,
        UPD_CIRC = 2'd1,
        UPD_BREV = 2'd2,
        UPD_NONE = 2'd3
    } upd_e;

    typedef enum logic [1:0] {
        SZ_SINGLE = 2'd0,
        SZ_DUAL   = 2'd1,
        SZ_QUAD   = 2'd2,
        SZ_RSVD   = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        RK_PTR  = 2'd0,
        RK_MOD  = 2'd1,
        RK_BASE = 2'd2,
        RK_LEN  = 2'd3
    } rkind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } st_e;
endpackage

// File: rtl/agu_regfile.sv
`timescale 1ns/1ps
module agu_regfile
    import agu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NBUF = 4,
    parameter int IW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  rkind_e        wr_kind,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [AW-1:0] wb_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] rd_mod,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_len
);
    logic [AW-1:0] ptr_q  [NBUF];
    logic [AW-1:0] mod_q  [NBUF];
    logic [AW-1:0] base_q [NBUF];
    logic [AW-1:0] len_q  [NBUF];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) begin
                ptr_q[i]  <= '0;
                mod_q[i]  <= '0;
                base_q[i] <= '0;
                len_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NBUF; i++) begin
                // Port write has priority over the stage write-back (R12)
                if (wr_en && wr_idx == IW'(i) && wr_kind == RK_PTR)
                    ptr_q[i] <= wr_data;
                else if (wb_en && wb_idx == IW'(i))
                    ptr_q[i] <= wb_data;
                if (wr_en && wr_idx == IW'(i) && wr_kind == RK_MOD)
                    mod_q[i] <= wr_data;
                if (wr_en && wr_idx == IW'(i) && wr_kind == RK_BASE)
                    base_q[i] <= wr_data;
                if (wr_en && wr_idx == IW'(i) && wr_kind == RK_LEN)
                    len_q[i] <= wr_data;
            end
        end
    end

    assign rd_ptr  = ptr_q[rd_idx];
    assign rd_mod  = mod_q[rd_idx];
    assign rd_base = base_q[rd_idx];
    assign rd_len  = len_q[rd_idx];

    p_port_beats_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == RK_PTR && wb_en && wr_idx == wb_idx)
        |=> ptr_q[$past(wr_idx)] == $past(wr_data));

    p_wb_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(wr_en && wr_kind == RK_PTR && wr_idx == wb_idx))
        |=> ptr_q[$past(wb_idx)] == $past(wb_data));
endmodule

// File: rtl/agu_update.sv
`timescale 1ns/1ps
module agu_update
    import agu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mod,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  upd_e          upd,
    input  logic          pre,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] nptr,
    output logic          err
);
    localparam int SW = AW + 2;

    function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    logic signed [SW-1:0] sum_s, base_s, len_s, end_s, hi_s, lo_s;
    logic [AW:0]          mag;
    logic                 over;
    logic [AW-1:0]        circ_res, brev_res, tgt;

    always_comb begin
        sum_s  = $signed({2'b00, ptr}) + $signed({{2{mod[AW-1]}}, mod});
        base_s = $signed({2'b00, base});
        len_s  = $signed({2'b00, len});
        end_s  = base_s + len_s;
        hi_s   = sum_s - len_s;
        lo_s   = sum_s + len_s;
        mag    = mod[AW-1] ? ({1'b0, ~mod} + (AW+1)'(1)) : {1'b0, mod};
        over   = (len != '0) && (mag > {1'b0, len});

        // Compare-and-correct wrap: no alignment or power-of-two assumption
        if (len == '0)           circ_res = sum_s[AW-1:0];
        else if (sum_s >= end_s) circ_res = hi_s[AW-1:0];
        else if (sum_s < base_s) circ_res = lo_s[AW-1:0];
        else                     circ_res = sum_s[AW-1:0];

        brev_res = flip(flip(ptr) + flip(mod));

        err = 1'b0;
        unique case (upd)
            UPD_LIN:  tgt = sum_s[AW-1:0];
            UPD_CIRC: begin
                err = over;
                tgt = over ? ptr : circ_res;
            end
            UPD_BREV: tgt = brev_res;
            UPD_NONE: tgt = ptr;
        endcase

        addr = pre ? tgt : ptr;
        nptr = pre ? ptr : tgt;
    end
endmodule

// File: rtl/agu_ctrl.sv
`timescale 1ns/1ps
module agu_ctrl
    import agu_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_pre,
    input  upd_e          cmd_upd,
    input  logic [IW-1:0] cmd_idx,
    input  size_e         cmd_size,
    output logic          cmd_ready,
    output logic          accept,
    output logic          stg_valid,
    output logic          stg_pre,
    output upd_e          stg_upd,
    output logic [IW-1:0] stg_idx,
    output size_e         stg_size,
    output logic          wb_en
);
    st_e  state_q, state_d;
    logic pending, conflict;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        pending   = (state_q == ST_BUSY) && !stg_pre && (stg_upd != UPD_NONE);
        conflict  = cmd_valid && pending && (cmd_idx == stg_idx);
        cmd_ready = !conflict;
        accept    = cmd_valid && !conflict;
        wb_en     = pending;
        stg_valid = (state_q == ST_BUSY);
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_BUSY : ST_IDLE;  // T_ISSUE
            ST_BUSY: state_d = accept ? ST_BUSY : ST_IDLE;  // T_CHAIN / T_DRAIN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_pre  <= 1'b0;
            stg_upd  <= UPD_NONE;
            stg_idx  <= '0;
            stg_size <= SZ_SINGLE;
        end else if (accept) begin
            stg_pre  <= cmd_pre;
            stg_upd  <= cmd_upd;
            stg_idx  <= cmd_idx;
            stg_size <= cmd_size;
        end
    end

    p_accept_then_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> state_q == ST_BUSY);

    p_no_accept_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> state_q == ST_IDLE);

    p_stall_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready);
endmodule

// File: rtl/agu_addr_gen.sv
`timescale 1ns/1ps
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NBUF = 4,
    localparam int IW  = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_pre,
    input  logic [1:0]    cmd_upd,
    input  logic [IW-1:0] cmd_idx,
    input  logic          cmd_use_reg,
    input  logic [AW-1:0] cmd_imm,
    input  logic [1:0]    cmd_size,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [1:0]    out_size,
    output logic [AW-1:0] out_ptr,
    output logic          out_err
);
    logic          accept, stg_valid, stg_pre, wb_en, err;
    upd_e          stg_upd;
    size_e         stg_size;
    logic [IW-1:0] stg_idx;
    logic [AW-1:0] rd_ptr, rd_mod, rd_base, rd_len;
    logic [AW-1:0] op_ptr, op_mod, op_base, op_len;
    logic [AW-1:0] addr, nptr;

    agu_ctrl #(.IW(IW)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_pre(cmd_pre),
        .cmd_upd(upd_e'(cmd_upd)), .cmd_idx(cmd_idx),
        .cmd_size(size_e'(cmd_size)),
        .cmd_ready(cmd_ready), .accept(accept),
        .stg_valid(stg_valid), .stg_pre(stg_pre), .stg_upd(stg_upd),
        .stg_idx(stg_idx), .stg_size(stg_size), .wb_en(wb_en)
    );

    agu_regfile #(.AW(AW), .NBUF(NBUF), .IW(IW)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(rkind_e'(wr_kind)), .wr_idx(wr_idx),
        .wr_data(wr_data),
        .wb_en(wb_en), .wb_idx(stg_idx), .wb_data(nptr),
        .rd_idx(cmd_idx),
        .rd_ptr(rd_ptr), .rd_mod(rd_mod), .rd_base(rd_base), .rd_len(rd_len)
    );

    // Operand capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_ptr  <= '0;
            op_mod  <= '0;
            op_base <= '0;
            op_len  <= '0;
        end else if (accept) begin
            op_ptr  <= rd_ptr;
            op_mod  <= cmd_use_reg ? rd_mod : cmd_imm;
            op_base <= rd_base;
            op_len  <= rd_len;
        end
    end

    agu_update #(.AW(AW)) upd_i (
        .ptr(op_ptr), .mod(op_mod), .base(op_base), .len(op_len),
        .upd(stg_upd), .pre(stg_pre),
        .addr(addr), .nptr(nptr), .err(err)
    );

    assign out_valid = stg_valid;
    assign out_addr  = addr;
    assign out_ptr   = nptr;
    assign out_size  = stg_size;
    assign out_err   = stg_valid && err;

    p_err_freezes_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_ptr == op_ptr && out_addr == op_ptr));

    p_pre_keeps_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && stg_pre) |-> out_ptr == op_ptr);

    p_post_addr_is_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !stg_pre) |-> out_addr == op_ptr);

    p_len0_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_len == '0) |-> !out_err);
endmodule

// File: tb/agu_addr_gen_tb.sv
`timescale 1ns/1ps
module agu_addr_gen_tb_top;
    logic        clk, rst_n;
    logic        cmd_valid, cmd_ready, cmd_pre, cmd_use_reg;
    logic [1:0]  cmd_upd, cmd_idx, cmd_size;
    logic [31:0] cmd_imm;
    logic        wr_en;
    logic [1:0]  wr_kind, wr_idx;
    logic [31:0] wr_data;
    logic        out_valid, out_err;
    logic [31:0] out_addr, out_ptr;
    logic [1:0]  out_size;

    agu_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_pre(cmd_pre),
        .cmd_upd(cmd_upd), .cmd_idx(cmd_idx), .cmd_use_reg(cmd_use_reg),
        .cmd_imm(cmd_imm), .cmd_size(cmd_size),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_size(out_size),
        .out_ptr(out_ptr), .out_err(out_err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [31:0] m_ptr [4], m_mod [4], m_base [4], m_len [4];
    bit pend_v = 0;
    int pend_idx = 0;

    function automatic logic [31:0] brev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    task automatic model_calc(input bit pre, input int upd,
                              input logic [31:0] p, md, b, l,
                              output logic [31:0] ea, np, output bit er);
        longint s, sm, mg;
        logic [31:0] t;
        sm = longint'($signed(md));
        s  = longint'(p) + sm;
        er = 0;
        case (upd)
            0: t = s[31:0];
            1: begin
                if (l == 0) t = s[31:0];
                else begin
                    mg = (sm < 0) ? -sm : sm;
                    if (mg > longint'(l)) begin er = 1; t = p; end
                    else begin
                        if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
                        else if (s < longint'(b)) s = s + longint'(l);
                        t = s[31:0];
                    end
                end
            end
            2: t = brev32(brev32(p) + brev32(md));
            default: t = p;
        endcase
        if (pre) begin ea = t; np = p; end
        else     begin ea = p; np = t; end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int kind, input int idx, input logic [31:0] d);
        cmd_valid = 0;
        wr_en = 1; wr_kind = kind[1:0]; wr_idx = idx[1:0]; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
        pend_v = 0;
        case (kind)
            0: m_ptr[idx]  = d;
            1: m_mod[idx]  = d;
            2: m_base[idx] = d;
            default: m_len[idx] = d;
        endcase
    endtask

    task automatic idle();
        cmd_valid = 0;
        @(posedge clk); @(negedge clk);
        pend_v = 0;
        check("R10 no result without command", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic cmd(input bit pre, input int upd, input int idx, input bit ureg,
                       input logic [31:0] imm, input int size, input string tag);
        logic [31:0] ea, np, md;
        bit er, rdy;
        cmd_valid = 1; cmd_pre = pre; cmd_upd = upd[1:0]; cmd_idx = idx[1:0];
        cmd_use_reg = ureg; cmd_imm = imm; cmd_size = size[1:0];
        #1;
        rdy = !(pend_v && pend_idx == idx);
        check({tag, " R11 ready"}, {31'd0, cmd_ready}, {31'd0, rdy});
        if (!rdy) begin
            @(posedge clk); @(negedge clk);
            pend_v = 0;
            check({tag, " R11 stalled command not issued"}, {31'd0, out_valid}, 32'd0);
            #1;
            check({tag, " R11 ready after stall"}, {31'd0, cmd_ready}, 32'd1);
        end
        md = ureg ? m_mod[idx] : imm;
        model_calc(pre, upd, m_ptr[idx], md, m_base[idx], m_len[idx], ea, np, er);
        m_ptr[idx] = np;
        @(posedge clk); @(negedge clk);
        check({tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " addr"}, out_addr, ea);
        check({tag, " ptr"}, out_ptr, np);
        check({tag, " R7 err"}, {31'd0, out_err}, {31'd0, er});
        check({tag, " R9 size"}, {30'd0, out_size}, size);
        pend_v = (!pre && upd != 3);
        pend_idx = idx;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; cmd_valid = 0; cmd_pre = 0; cmd_upd = 0; cmd_idx = 0;
        cmd_use_reg = 0; cmd_imm = 0; cmd_size = 0;
        wr_en = 0; wr_kind = 0; wr_idx = 0; wr_data = 0;
        for (int i = 0; i < 4; i++) begin
            m_ptr[i] = 0; m_mod[i] = 0; m_base[i] = 0; m_len[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset ready", {31'd0, cmd_ready}, 32'd1);
        for (int i = 0; i < 4; i++) cmd(1, 3, i, 1, 0, 0, "R1 reset pointer read");
        idle();

        // R5 circular wrap at an odd base, both directions
        wr(2, 1, 32'h0000_1003); wr(3, 1, 32'd10); wr(0, 1, 32'h0000_100B); wr(1, 1, 32'd3);
        cmd(0, 1, 1, 1, 0, 2, "R5 R2 R4 post circular upper wrap");
        check("R5 literal wrap", out_ptr, 32'h0000_1004);
        idle();
        cmd(1, 1, 1, 0, -32'sd5, 1, "R5 R3 pre circular lower wrap");
        check("R5 literal lower", out_addr, 32'h0000_1009);

        // R6 zero length behaves linearly, code 0 linear
        wr(3, 1, 32'd0);
        cmd(0, 1, 1, 0, -32'sd4101, 0, "R6 zero length circular");
        cmd(0, 0, 2, 0, 32'd16, 0, "R6 linear");

        // R7 modifier magnitude above length
        wr(3, 1, 32'd10); wr(0, 1, 32'h0000_1005);
        cmd(0, 1, 1, 0, 32'd11, 0, "R7 oversized modifier");
        check("R7 literal ptr kept", out_ptr, 32'h0000_1005);

        // R8 bit-reverse carry from the MSB down; back-to-back same set stalls (R11)
        wr(0, 2, 32'd0); wr(1, 2, 32'h8000_0000);
        cmd(0, 2, 2, 1, 0, 2, "R8 bitrev step1");
        check("R8 literal step1", out_ptr, 32'h8000_0000);
        cmd(0, 2, 2, 1, 0, 2, "R8 R11 bitrev step2 after stall");
        check("R8 literal step2", out_ptr, 32'h4000_0000);

        // R10 back-to-back different sets without stall
        cmd(0, 0, 0, 0, 32'd4, 0, "R10 chain set0");
        cmd(0, 0, 3, 0, 32'd8, 1, "R10 chain set3");
        cmd(0, 0, 0, 0, 32'd4, 2, "R10 chain set0 again");

        // R12 port write beats write-back; new base used at once
        wr(0, 0, 32'hABCD_0000);
        cmd(1, 3, 0, 0, 0, 0, "R12 port write wins");
        check("R12 literal", out_addr, 32'hABCD_0000);
        wr(2, 3, 32'hFFFF_FFF0); wr(3, 3, 32'd32); wr(0, 3, 32'hFFFF_FFFE);
        cmd(0, 1, 3, 0, 32'd4, 0, "R12 R5 base crossing top of space");

        // R13 sets are independent
        wr(0, 2, 32'h1234_5678);
        for (int i = 0; i < 4; i++) cmd(1, 3, i, 0, 0, 3, "R13 set isolation");
        idle();

        // Random mix
        for (int it = 0; it < 1500; it++) begin
            int sel, idx;
            sel = int'($urandom % 10);
            idx = int'($urandom % 4);
            if (sel == 0) idle();
            else if (sel < 3) begin
                int kind;
                logic [31:0] d;
                kind = int'($urandom % 4);
                case (kind)
                    0: d = m_base[idx] + ($urandom % (m_len[idx] + 1));
                    1: d = ($urandom % 8 == 0) ? $urandom : ($urandom % 129) - 32'd64;
                    2: d = $urandom;
                    default: d = $urandom % 64;
                endcase
                wr(kind, idx, d);
            end else begin
                cmd(bit'($urandom % 2), int'($urandom % 4), idx, bit'($urandom % 2),
                    ($urandom % 97) - 32'd48, int'($urandom % 4), "R2 R3 R5 R8 random");
            end
        end
        idle();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule